// File: doc/BRIEF.md
# Countdown Interval Timer

A 32-bit down-counting timer that sits on a simple single-cycle register bus. Software loads a period and then starts or stops the counter with pulse bits in a control write. When the count runs out, a sticky timeout flag is set. In continuous mode the counter reloads from the period and keeps going. In one-shot mode it halts at zero. A level interrupt is raised while both the timeout flag and the interrupt-enable bit are set.

The bus uses a byte address, a write strobe, a read strobe, write data and registered read data. A read strobe seen at a clock edge places the selected word on the read-data port after that edge, and the port holds the value until the next read. The port list carries no streaming data, so the block has no valid/ready handshake. Every access completes in one cycle and is never back-pressured.

Top module: `intv_timer`

## Requirements
- R1: Byte-address bits [ADDR_W-1:2] select a word. Index 0 is status, 1 is control, 2 is period and 3 is snapshot. Address bits [1:0] are ignored. Any other index reads as zero and ignores writes. Read data appears on the cycle after the read strobe is sampled and holds until the next read.
- R2: The status word has the timeout flag in bit 0 and the running flag in bit 1. All other status bits read zero.
- R3: A control write stores the whole data word, and control reads return it. Bit 0 is interrupt enable, bit 1 is continuous mode, bit 2 is start and bit 3 is stop.
- R4: Any write to status clears the timeout flag whatever the data, and leaves every other register unchanged. An expiry in the same cycle wins, so the flag stays set.
- R5: `irq` is high exactly while the timeout flag and control bit 0 are both set. It follows each write and each expiry on the next clock edge, and a control write alone can raise it.
- R6: A period write stores the value and loads it into the live counter at that edge, with no decrement in that cycle. The running state is not changed.
- R7: A control write with bit 2 set makes the counter run. Bit 3 halts it, and bit 3 wins when both are set. A control write with neither bit leaves the run state as it is.
- R8: While running, the count falls by one per clock. An edge at which the count is 1, or 0, is an expiry, and it sets the timeout flag. From a start on period P (P≥2) the flag is set on the (P-1)th clock after the start edge. For P of 0 or 1 it is set at the start edge.
- R9: On expiry in continuous mode, the counter reloads the period and keeps running. The mode is taken from the control word being written in that cycle, if there is one. This gives an expiry every max(P,1) clocks. On expiry in one-shot mode, the counter halts with a count of 0.
- R10: A snapshot read returns the live count as it stood at the read edge. Writes to the snapshot word change nothing.
- R11: Reset clears status, control, period and count, stops the counter and drives `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
The one-shot sweep starts the counter on every period from 0 to 12 and counts clocks to the interrupt. This separates the off-by-one expiry point and the immediate expiry on 0 and 1. The continuous sweep over periods 0 to 8 clears the flag right after each expiry and measures the next interval. This shows whether the reload value is correct and whether a set in the same cycle beats the clear. The remaining directed patterns cover these cases:
- start and stop together, which checks precedence;
- a period write while running, which checks the immediate load;
- back-to-back snapshot reads, which check the live count;
- the interrupt-enable bit toggled after a timeout, which checks the level gating;
- aliased and unmapped addresses, which check the decode.

// File: rtl/intv_pkg.sv
package intv_pkg;
  typedef enum logic [1:0] {
    IDX_STAT = 2'd0,
    IDX_CTRL = 2'd1,
    IDX_PER  = 2'd2,
    IDX_SNAP = 2'd3
  } word_idx_e;

  localparam int NUM_WORDS = 4;

  localparam int CB_IE    = 0;
  localparam int CB_CONT  = 1;
  localparam int CB_START = 2;
  localparam int CB_STOP  = 3;

  localparam int SB_TO  = 0;
  localparam int SB_RUN = 1;
endpackage

// File: rtl/intv_decode.sv
module intv_decode
  import intv_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr,
  input  logic                 rd,
  output logic [NUM_WORDS-1:0] wr_sel,
  output logic [NUM_WORDS-1:0] rd_sel
);
  logic       mapped;
  logic [1:0] idx;
  logic       unused_lowbits;

  assign idx            = addr[3:2];
  assign unused_lowbits = ^addr[1:0];

  generate
    if (ADDR_W > 4) begin : g_high
      assign mapped = ~|addr[ADDR_W-1:4];
    end else begin : g_flat
      assign mapped = 1'b1;
    end
  endgenerate

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_sel
    assign wr_sel[i] = wr & mapped & (idx == 2'(i));
    assign rd_sel[i] = rd & mapped & (idx == 2'(i));
  end
endmodule

// File: rtl/intv_regfile.sv
module intv_regfile
  import intv_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stat,
  input  logic              wr_ctrl,
  input  logic              wr_per,
  input  logic [DATA_W-1:0] wdata,
  input  logic              expire,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] period_q,
  output logic              to_q,
  output logic              start,
  output logic              stop,
  output logic              cont,
  output logic              irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      period_q <= '0;
      to_q     <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata;
      if (wr_per)  period_q <= wdata;
      if (expire)       to_q <= 1'b1;
      else if (wr_stat) to_q <= 1'b0;
    end
  end

  assign start = wr_ctrl & wdata[CB_START];
  assign stop  = wr_ctrl & wdata[CB_STOP];
  assign cont  = wr_ctrl ? wdata[CB_CONT] : ctrl_q[CB_CONT];
  assign irq   = to_q & ctrl_q[CB_IE];
endmodule

// File: rtl/intv_counter.sv
module intv_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [DATA_W-1:0] ld_val,
  input  logic              start,
  input  logic              stop,
  input  logic              cont,
  input  logic [DATA_W-1:0] period,
  output logic [DATA_W-1:0] cnt_q,
  output logic              run_q,
  output logic              expire
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic              run_eff;
  logic              run_d;
  logic [DATA_W-1:0] cnt_d;

  always_comb begin
    run_eff = (run_q | start) & ~stop;
    run_d   = run_eff;
    cnt_d   = cnt_q;
    expire  = 1'b0;
    if (ld) begin
      cnt_d = ld_val;
    end else if (run_eff) begin
      if (cnt_q <= ONE) begin
        expire = 1'b1;
        if (cont) begin
          cnt_d = period;
        end else begin
          cnt_d = '0;
          run_d = 1'b0;
        end
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end
endmodule

// File: rtl/intv_rdmux.sv
module intv_rdmux
  import intv_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WORDS-1:0] rd_sel,
  input  logic                 rd,
  input  logic [DATA_W-1:0]    stat_w,
  input  logic [DATA_W-1:0]    ctrl_w,
  input  logic [DATA_W-1:0]    per_w,
  input  logic [DATA_W-1:0]    cnt_w,
  output logic [DATA_W-1:0]    rdata
);
  logic [DATA_W-1:0] words [NUM_WORDS];
  logic [DATA_W-1:0] mux;

  assign words[IDX_STAT] = stat_w;
  assign words[IDX_CTRL] = ctrl_w;
  assign words[IDX_PER]  = per_w;
  assign words[IDX_SNAP] = cnt_w;

  always_comb begin
    mux = '0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (rd_sel[i]) mux = mux | words[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= mux;
  end
endmodule

// File: rtl/intv_timer.sv
module intv_timer
  import intv_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic [NUM_WORDS-1:0] wr_sel;
  logic [NUM_WORDS-1:0] rd_sel;
  logic [DATA_W-1:0]    ctrl_q;
  logic [DATA_W-1:0]    period_q;
  logic [DATA_W-1:0]    cnt_q;
  logic [DATA_W-1:0]    stat_w;
  logic                 to_q;
  logic                 run_q;
  logic                 expire;
  logic                 start;
  logic                 stop;
  logic                 cont;

  intv_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr   (bus_addr),
    .wr     (bus_wr),
    .rd     (bus_rd),
    .wr_sel (wr_sel),
    .rd_sel (rd_sel)
  );

  intv_regfile #(.DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stat  (wr_sel[IDX_STAT]),
    .wr_ctrl  (wr_sel[IDX_CTRL]),
    .wr_per   (wr_sel[IDX_PER]),
    .wdata    (bus_wdata),
    .expire   (expire),
    .ctrl_q   (ctrl_q),
    .period_q (period_q),
    .to_q     (to_q),
    .start    (start),
    .stop     (stop),
    .cont     (cont),
    .irq      (irq)
  );

  intv_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (wr_sel[IDX_PER]),
    .ld_val (bus_wdata),
    .start  (start),
    .stop   (stop),
    .cont   (cont),
    .period (period_q),
    .cnt_q  (cnt_q),
    .run_q  (run_q),
    .expire (expire)
  );

  always_comb begin
    stat_w         = '0;
    stat_w[SB_TO]  = to_q;
    stat_w[SB_RUN] = run_q;
  end

  intv_rdmux #(.DATA_W(DATA_W)) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_sel (rd_sel),
    .rd     (bus_rd),
    .stat_w (stat_w),
    .ctrl_w (ctrl_q),
    .per_w  (period_q),
    .cnt_w  (cnt_q),
    .rdata  (bus_rdata)
  );
endmodule

// File: rtl/intv_timer_chk.sv
module intv_timer_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              irq,
  input logic [DATA_W-1:0] cnt,
  input logic              run,
  input logic              to,
  input logic              expire,
  input logic [DATA_W-1:0] ctrl,
  input logic [DATA_W-1:0] period
);
  localparam int IDX_W = ADDR_W - 2;

  logic w_stat, w_ctrl, w_per, cont_now;
  assign w_stat   = bus_wr && (bus_addr[ADDR_W-1:2] == IDX_W'(0));
  assign w_ctrl   = bus_wr && (bus_addr[ADDR_W-1:2] == IDX_W'(1));
  assign w_per    = bus_wr && (bus_addr[ADDR_W-1:2] == IDX_W'(2));
  assign cont_now = w_ctrl ? bus_wdata[1] : ctrl[1];

  AST_CLEAR_TO: assert property (@(posedge clk) disable iff (!rst_n)
    (w_stat && !expire) |=> !to); // R4
  AST_SET_TO: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> to); // R8
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(expire) || $past(w_ctrl))); // R5
  AST_PERIOD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    w_per |=> (cnt == $past(bus_wdata))); // R6
  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (w_ctrl && bus_wdata[3]) |=> !run); // R7
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !w_per && !(w_ctrl && bus_wdata[3]) && cnt > DATA_W'(1))
      |=> (cnt == $past(cnt) - DATA_W'(1))); // R8
  AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !cont_now) |=> (!run && cnt == '0)); // R9
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && cont_now) |=> (run && cnt == $past(period))); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !w_per && !w_ctrl) |=> $stable(cnt)); // R10
endmodule

bind intv_timer intv_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .irq       (irq),
  .cnt       (cnt_q),
  .run       (run_q),
  .to        (to_q),
  .expire    (expire),
  .ctrl      (ctrl_q),
  .period    (period_q)
);

// File: tb/intv_timer_test.sv
`timescale 1ns/1ps
module intv_timer_test;
  localparam int DW = 32;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  intv_timer #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_irq(input int limit, output int n);
    n = 0;
    while (!irq && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    logic [31:0] v;
    int n;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check("R11 irq after reset", 32'(irq), 0);
    for (int a = 0; a < 4; a++) begin
      rd(AW'(a * 4), v);
      check("R11 word after reset", v, 0);
    end

    // R1 decode: aliasing of low bits, unmapped words
    wr(5'h08, 32'h33);
    rd(5'h0B, v); check("R1 low bits ignored", v, 32'h33);
    wr(5'h10, 32'hAA);
    rd(5'h10, v); check("R1 unmapped reads zero", v, 0);
    rd(5'h1C, v); check("R1 unmapped reads zero", v, 0);
    rd(5'h08, v); check("R1 unmapped write ignored", v, 32'h33);

    // R3 full control word kept
    wr(5'h04, 32'hABC0);
    rd(5'h04, v); check("R3 control readback", v, 32'hABC0);
    rd(5'h00, v); check("R2 idle status", v, 0);

    // R10 snapshot and write to it ignored
    rd(5'h0C, v); check("R10 snapshot after period load", v, 32'h33);
    wr(5'h0C, 32'h5);
    rd(5'h0C, v); check("R10 snapshot write ignored", v, 32'h33);
    rd(5'h08, v); check("R10 period after snapshot write", v, 32'h33);

    // R8 R9 one-shot sweep
    for (int p = 0; p <= 12; p++) begin
      wr(5'h08, 32'(p));
      wr(5'h04, 32'h5);
      wait_irq(40, n);
      check("R8 one-shot expiry delay", 32'(n), (p <= 1) ? 0 : 32'(p - 1));
      rd(5'h00, v); check("R9 one-shot halts (R2 status)", v, 32'h1);
      rd(5'h0C, v); check("R9 one-shot count zero", v, 0);
      wr(5'h00, 32'hFFFF_FFFF);
      check("R4 status write clears irq", 32'(irq), 0);
      rd(5'h04, v); check("R4 control untouched", v, 32'h5);
    end

    // R9 continuous sweep, R4 set-wins on same-cycle clear
    for (int p = 0; p <= 8; p++) begin
      int exp_n;
      exp_n = (p <= 1) ? 0 : p - 1;
      wr(5'h08, 32'(p));
      wr(5'h04, 32'h7);
      wait_irq(40, n);
      check("R9 first continuous expiry", 32'(n), 32'(exp_n));
      for (int k = 0; k < 3; k++) begin
        wr(5'h00, 32'h0);
        wait_irq(40, n);
        check("R9 continuous interval", 32'(n), 32'(exp_n));
      end
      rd(5'h00, v); check("R9 continuous keeps running", v[1], 1);
      wr(5'h04, 32'h8);
      rd(5'h00, v); check("R7 stop halts", v[1], 0);
      wr(5'h00, 32'h0);
    end

    // R7 start and stop together
    wr(5'h08, 32'd50);
    wr(5'h04, 32'hC);
    rd(5'h00, v); check("R7 stop wins over start", v, 0);
    rd(5'h0C, v); check("R7 count untouched", v, 32'd50);

    // R10 live count, R7 stop freezes
    wr(5'h04, 32'h4);
    rd(5'h0C, v); check("R10 live count", v, 32'd49);
    rd(5'h0C, v); check("R10 live count next", v, 32'd48);
    wr(5'h04, 32'h8);
    rd(5'h0C, v); check("R7 frozen count", v, 32'd47);
    rd(5'h0C, v); check("R7 frozen count again", v, 32'd47);

    // R6 period write while running
    wr(5'h04, 32'h4);
    wr(5'h08, 32'd500);
    rd(5'h0C, v); check("R6 immediate load", v, 32'd500);
    rd(5'h00, v); check("R6 run state kept", v, 32'h2);
    wr(5'h04, 32'h8);

    // R5 interrupt gating
    wr(5'h08, 32'd3);
    wr(5'h04, 32'h4);
    repeat (5) @(negedge clk);
    check("R5 irq gated off", 32'(irq), 0);
    rd(5'h00, v); check("R5 timeout pending", v, 32'h1);
    wr(5'h04, 32'h1);
    check("R5 enabling raises irq", 32'(irq), 1);
    rd(5'h00, v); check("R7 no start keeps halted", v, 32'h1);
    wr(5'h04, 32'h0);
    check("R5 disabling drops irq", 32'(irq), 0);

    // R11 reset mid-run
    wr(5'h08, 32'd100);
    wr(5'h04, 32'h7);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 irq after mid-run reset", 32'(irq), 0);
    for (int a = 0; a < 4; a++) begin
      rd(AW'(a * 4), v);
      check("R11 word after mid-run reset", v, 0);
    end
    repeat (3) @(negedge clk);
    rd(5'h0C, v); check("R11 counter stopped", v, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule